// File: doc/BRIEF.md
# Power-Domain Request Register File

This block is a word-wide register file for a power controller. It is reached through a one-access-per-cycle register port with an access enable, a write enable, a byte address and write data. Read data returns one cycle later. Every register is 32 bits wide and clears to zero on reset. Most registers store whatever software writes to them.

Two registers behave differently. The power-up request register is at byte offset 0x0F8 and the power-down request register is at byte offset 0x104. Their five lowest bits are per-domain request bits. These bits clear themselves as the write lands, so software reads them back as zero, and that zero means the request is complete. The upper bits of these two registers keep their written value. Each request register also has a one-cycle completion pulse. The pulse fires after any write that sets one or more of its request bits.

The port accepts an access in every cycle with `acc_en` high and never applies back-pressure. A read returns its result on `rd_valid`/`rd_data` one cycle later, and that result cannot be stalled. An access to an unaligned or out-of-range address does nothing when it is a write. When it is a read, it returns zero.

Top module: `pwr_req_regfile`

## Requirements
- R1: After reset, every register reads zero and `rd_valid`, `pup_done` and `pdn_done` are low.
- R2: A read access (acc_en=1, acc_we=0) raises `rd_valid` for exactly the following cycle, with `rd_data` equal to the addressed register's contents before that edge. Write accesses raise no `rd_valid`.
- R3: A write to any aligned, in-range offset other than 0x0F8 and 0x104 stores all 32 bits, and later reads return that value unchanged.
- R4: A write to offset 0x0F8 stores bits [31:5] as written, and bits [4:0] read back as zero. The request bits map as follows: bit 0 camera-serial PHY, bit 1 PCIe PHY, bit 2 first USB OTG PHY, bit 3 second USB OTG PHY, bit 4 USB inter-chip PHY.
- R5: A write to offset 0x104 behaves like R4: bits [31:5] are kept, bits [4:0] read back as zero, and the domain-to-bit map is the same.
- R6: `pup_done` (or `pdn_done`) is high for exactly the one cycle after a write to 0x0F8 (or 0x104) in which any of bits [4:0] is one. It stays low if those bits are all zero, and it never rises for any other access.
- R7: A write whose address has a nonzero bit [1] or bit [0], or whose address lies at or beyond NUM_REGS*4, changes no register.
- R8: A read of an unaligned or out-of-range address still raises `rd_valid` and returns zero.
- R9: Asserting reset after registers have been written returns every register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | Access valid; always accepted |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (12) | Byte address |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read result valid, one cycle after a read access |
| rd_data | output | 32 | Read result |
| pup_done | output | 1 | Power-up request completion pulse |
| pdn_done | output | 1 | Power-down request completion pulse |

## Verification
The bench uses the default parameters: 72 registers, a 12-bit address and 5 request bits. With these values every register in the file, and every address past its end up to the top of the 4 KiB window, can be swept one by one. It fills each register with a computed pattern and reads the whole file back. Each request bit is toggled on its own to test the completion pulses. The bench tries all three unaligned byte offsets on each register, and it sets a reset in the middle of the run against a fully written file.

// File: rtl/pwr_req_pkg.sv
package pwr_req_pkg;
  localparam int unsigned WORD_W = 32;

  // Mask of self-clearing request bits for a given request width.
  function automatic logic [WORD_W-1:0] req_mask(input int unsigned bits);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int unsigned b = 0; b < WORD_W; b++) begin
      if (b < bits) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/pwr_req_decode.sv
module pwr_req_decode #(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 72,
  parameter int unsigned UP_OFS   = 32'h0F8,
  parameter int unsigned DN_OFS   = 32'h104,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic              up_sel,
  output logic              dn_sel
);
  localparam int unsigned WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] LIMIT = WIDX_W'(NUM_REGS);

  logic [WIDX_W-1:0] word_idx;
  logic              aligned;

  always_comb begin
    word_idx = addr[ADDR_W-1:2];
    aligned  = (addr[1:0] == 2'b00);
    hit      = aligned && (word_idx < LIMIT);
    idx      = word_idx[IDX_W-1:0];
    up_sel   = hit && (addr == ADDR_W'(UP_OFS));
    dn_sel   = hit && (addr == ADDR_W'(DN_OFS));
  end
endmodule

// File: rtl/pwr_req_bank.sv
module pwr_req_bank
  import pwr_req_pkg::*;
#(
  parameter int unsigned NUM_REGS = 72,
  parameter int unsigned UP_IDX   = 62,
  parameter int unsigned DN_IDX   = 65,
  parameter int unsigned REQ_BITS = 5,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_word
);
  localparam logic [WORD_W-1:0] CLR = req_mask(REQ_BITS);

  logic [WORD_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_REGS; k++) regs[k] <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < NUM_REGS; k++) begin
        if (idx == IDX_W'(k)) begin
          if (k == UP_IDX || k == DN_IDX) regs[k] <= wr_data & ~CLR;
          else                            regs[k] <= wr_data;
        end
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (idx == IDX_W'(k)) rd_word = regs[k];
    end
  end

  // Request bits never survive in storage (R4, R5)
  p_req_bits_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (regs[UP_IDX] & CLR) == '0);
  p_req_bits_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (regs[DN_IDX] & CLR) == '0);
endmodule

// File: rtl/pwr_req_done.sv
module pwr_req_done #(
  parameter int unsigned REQ_BITS = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel,
  input  logic                wr,
  input  logic [REQ_BITS-1:0] req,
  output logic                done
);
  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= sel && wr && (|req);
  end

  // Pulse only follows a write (R6)
  p_done_after_write_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(wr));
endmodule

// File: rtl/pwr_req_regfile.sv
module pwr_req_regfile
  import pwr_req_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 72,
  parameter int unsigned UP_OFS   = 32'h0F8,
  parameter int unsigned DN_OFS   = 32'h104,
  parameter int unsigned REQ_BITS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              pup_done,
  output logic              pdn_done
);
  localparam int unsigned IDX_W  = $clog2(NUM_REGS);
  localparam int unsigned UP_IDX = UP_OFS / 4;
  localparam int unsigned DN_IDX = DN_OFS / 4;

  logic             hit, up_sel, dn_sel;
  logic [IDX_W-1:0] idx;
  logic [WORD_W-1:0] rd_word;
  logic             wr_go;
  logic [1:0]       sel_v;
  logic [1:0]       done_v;

  pwr_req_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .UP_OFS(UP_OFS), .DN_OFS(DN_OFS)
  ) u_dec (
    .addr(acc_addr), .hit(hit), .idx(idx), .up_sel(up_sel), .dn_sel(dn_sel)
  );

  assign wr_go = acc_en && acc_we && hit;

  pwr_req_bank #(
    .NUM_REGS(NUM_REGS), .UP_IDX(UP_IDX), .DN_IDX(DN_IDX), .REQ_BITS(REQ_BITS)
  ) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_go), .idx(idx),
    .wr_data(acc_wdata), .rd_word(rd_word)
  );

  assign sel_v = {dn_sel, up_sel};

  for (genvar g = 0; g < 2; g++) begin : g_done
    pwr_req_done #(.REQ_BITS(REQ_BITS)) u_done (
      .clk(clk), .rst(rst), .sel(sel_v[g]), .wr(acc_en && acc_we),
      .req(acc_wdata[REQ_BITS-1:0]), .done(done_v[g])
    );
  end

  assign pup_done = done_v[0];
  assign pdn_done = done_v[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_en && !acc_we;
      rd_data  <= (acc_en && !acc_we && hit) ? rd_word : '0;
    end
  end

  // R2: read result only after a read access
  p_rd_after_read_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(acc_en && !acc_we));
  // R8: bad-address reads return zero
  p_bad_read_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(!hit)) |-> (rd_data == '0));
  // R4/R5: request-register reads never show request bits
  p_req_read_low_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(up_sel || dn_sel)) |-> (rd_data[REQ_BITS-1:0] == '0));
  // R6: the two pulses are exclusive
  p_done_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(pup_done && pdn_done));
endmodule

// File: tb/test_pwr_req_regfile.sv
module test_pwr_req_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 72;
  localparam int UPI = 62;
  localparam int DNI = 65;
  localparam int WDOG = 100000;

  logic        clk = 0;
  logic        rst = 1;
  logic        acc_en = 0, acc_we = 0;
  logic [11:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic        rd_valid, pup_done, pdn_done;
  logic [31:0] rd_data;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_req_regfile i_pwr_req_regfile (
    .clk(clk), .rst(rst), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .pup_done(pup_done), .pdn_done(pdn_done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG && !finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int i, input int salt);
    return (32'h9E3779B9 * (i + 1 + salt)) ^ (32'(i) << 8);
  endfunction

  function automatic logic [31:0] stored(input int i, input logic [31:0] v);
    return (i == UPI || i == DNI) ? (v & ~32'h1F) : v;
  endfunction

  // Write at a negedge; sample pulses at the next negedge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input string req, input bit exp_up, input bit exp_dn);
    acc_en = 1; acc_we = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_we = 0;
    check(req, {30'b0, pup_done, pdn_done}, {30'b0, exp_up, exp_dn});
    check({req, " no rd_valid"}, {31'b0, rd_valid}, 32'b0);
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    acc_en = 1; acc_we = 0; acc_addr = a;
    @(negedge clk);
    acc_en = 0;
    check({req, " rd_valid"}, {31'b0, rd_valid}, 32'd1);
    check(req, rd_data, exp);
  endtask

  logic [31:0] model [NREG];

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 rd_valid", {31'b0, rd_valid}, 32'b0);
    check("R1 pulses", {30'b0, pup_done, pdn_done}, 32'b0);
    for (int i = 0; i < NREG; i++) rd(12'(4*i), 32'h0, "R1 zero");
    @(negedge clk);
    check("R2 rd_valid drops", {31'b0, rd_valid}, 32'b0);

    // R3/R4/R5 sweep: write every register
    for (int i = 0; i < NREG; i++) begin
      logic [31:0] v;
      v = pat(i, 0);
      model[i] = stored(i, v);
      wr(12'(4*i), v, "R3 write",
         (i == UPI) && (v[4:0] != 0), (i == DNI) && (v[4:0] != 0));
    end
    for (int i = 0; i < NREG; i++)
      rd(12'(4*i), model[i], (i == UPI) ? "R4 up readback" :
                             (i == DNI) ? "R5 dn readback" : "R3 readback");

    // R4/R5/R6 request bits one by one
    for (int b = 0; b < 5; b++) begin
      wr(12'h0F8, 32'hC0000000 | (32'h1 << b), "R6 up pulse bit", 1, 0);
      rd(12'h0F8, 32'hC0000000, "R4 bit cleared");
      wr(12'h104, 32'h30000000 | (32'h1 << b), "R6 dn pulse bit", 0, 1);
      rd(12'h104, 32'h30000000, "R5 bit cleared");
    end
    wr(12'h0F8, 32'hFFFFFFFF, "R6 up all", 1, 0);
    rd(12'h0F8, 32'hFFFFFFE0, "R4 upper kept");
    wr(12'h104, 32'hFFFFFFFF, "R6 dn all", 0, 1);
    rd(12'h104, 32'hFFFFFFE0, "R5 upper kept");
    wr(12'h0F8, 32'hABCD0000, "R6 up no req", 0, 0);
    rd(12'h0F8, 32'hABCD0000, "R4 no req");
    wr(12'h104, 32'h12340000, "R6 dn no req", 0, 0);
    rd(12'h104, 32'h12340000, "R5 no req");
    model[UPI] = 32'hABCD0000;
    model[DNI] = 32'h12340000;
    rd(12'h0F8, 32'hABCD0000, "R6 read no pulse");
    check("R6 read no pulse", {30'b0, pup_done, pdn_done}, 32'b0);

    // R7 unaligned writes, including at request offsets
    for (int i = 0; i < NREG; i++)
      for (int o = 1; o < 4; o++)
        wr(12'(4*i + o), ~pat(i, o), "R7 unaligned write", 0, 0);
    // R7 out-of-range writes
    for (int a = NREG*4; a < 4096; a += 4)
      wr(12'(a), 32'hDEADBEEF, "R7 out-of-range write", 0, 0);
    for (int i = 0; i < NREG; i++) rd(12'(4*i), model[i], "R7 unchanged");

    // R8 bad-address reads
    for (int o = 1; o < 4; o++) rd(12'(4*3 + o), 32'h0, "R8 unaligned read");
    for (int a = NREG*4; a < 4096; a += 256) rd(12'(a), 32'h0, "R8 range read");
    rd(12'hFFC, 32'h0, "R8 top read");

    // R9 reset with full file
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    for (int i = 0; i < NREG; i++) rd(12'(4*i), 32'h0, "R9 cleared");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule